// File: doc/BRIEF.md
# Bus Address Decoder with Boot Overlay

This block decodes the 24-bit byte address of a 16-bit, big-endian processor bus into a set of chip selects. The selects cover a 1 MiB RAM, a 64 KiB read-only boot ROM and ten peripheral windows. The block works out each access's byte count from the size code, so a word or longword that would spill past the end of its region is refused. Such an access, like any access that hits no region, raises a bus error in place of a select.

With each select the block also gives an offset. For RAM and ROM this is the byte offset into the array. For a peripheral it is the register offset: the distance from the window base, halved when the window base is odd. An odd base means the peripheral sits on a single byte lane, and its registers appear at every second byte address.

After reset a boot overlay is active. During the overlay the only accesses accepted are longword reads at address 0 and address 4. These two reads fetch the initial stack pointer and program counter, and the block steers them into the ROM. Every other access during the overlay is an error. The overlay drops once the read at address 4 has been taken, and from then on the normal map applies.

Top module: `busdec_top`

## Requirements
- R1: While `strobe` is low, every select and `bus_err` are low, and both offsets are zero.
- R2: After the overlay, an access of size n (byte=0 gives n=1, word=1 gives n=2, longword=2 gives n=4) selects RAM with `mem_off` = address when it lies wholly inside 0x010000..0x0FFFFF or wholly below 0x010000.
- R3: A word or longword that starts below 0x010000 and ends at or above it belongs to neither RAM range and raises `bus_err`.
- R4: After the overlay, a read lying wholly inside 0x100000..0x10FFFF selects ROM with `mem_off` = address − 0x100000.
- R5: A write to 0x100000..0x10FFFF never selects ROM and raises `bus_err`.
- R6: Peripheral 0 covers 0x180000..0x1FFFFF and peripheral 1 covers 0x200000..0x27FFFF. An access wholly inside either one sets only its bit of `sel_per`, with `per_off` = address − base.
- R7: Peripherals 2..9 have base 0x3A0001 + (k−2)·0x4000 and span 0x4000 (end exclusive). An access wholly inside one sets its bit of `sel_per`, with `per_off` = (address − base) / 2.
- R8: An access that lies wholly inside no region, or that crosses a region's end, raises `bus_err`.
- R9: After reset `boot_active` is high. While it is high, a longword read at address 0 or 4 selects ROM with `mem_off` equal to the address.
- R10: While `boot_active` is high, every other strobed access raises `bus_err` and selects nothing.
- R11: `boot_active` falls in the cycle after a strobed longword read at address 4 and stays low until the next reset. A read at address 0 leaves it high.
- R12: In any cycle, at most one of `sel_ram`, `sel_rom`, the `sel_per` bits and `bus_err` is high.
- R13: Size code 3 is invalid and raises `bus_err` wherever it is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; arms the boot overlay |
| strobe | input | 1 | Access valid this cycle |
| rd | input | 1 | 1 = read, 0 = write |
| size | input | 2 | 0 byte, 1 word, 2 longword, 3 invalid |
| addr | input | 24 | Byte address of the first (most significant) byte |
| sel_ram | output | 1 | RAM select |
| sel_rom | output | 1 | Boot ROM select |
| sel_per | output | 10 | One-hot peripheral selects |
| mem_off | output | 20 | Byte offset into RAM or ROM |
| per_off | output | 20 | Register offset in the selected peripheral |
| bus_err | output | 1 | Strobed access not mapped |
| boot_active | output | 1 | Boot overlay armed |

## Verification
The assertions watch the following on every cycle:
- the outputs are at most one-hot;
- the outputs are quiet when no strobe is given;
- ROM is never selected on a write;
- the overlay steers the two vector reads and refuses everything else;
- the overlay flag clears after the address-4 read and never comes back before reset.

Some behaviour only the bench scenarios can show. These are the exact region edges, the fit test for multi-byte accesses at each edge and across 0x010000, the halved offsets on the odd windows, and address wrap at the top of the map. The bench sweeps addresses around every region edge with every size and direction, and compares each result with an arithmetic model.

// File: rtl/busdec_pkg.sv
package busdec_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_BAD  = 2'd3
    } size_e;

    // number of bytes minus one; invalid code treated as a byte (flagged elsewhere)
    function automatic logic [1:0] span_minus_one(size_e s);
        case (s)
            SZ_WORD: return 2'd1;
            SZ_LONG: return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/busdec_win.sv
module busdec_win #(
    parameter int unsigned BASE  = 0,
    parameter int unsigned SPAN  = 16,
    parameter int unsigned OFF_W = 20
) (
    input  logic [23:0]      addr,
    input  logic [24:0]      last,
    output logic             hit,
    output logic [OFF_W-1:0] off
);
    localparam logic [24:0] LO = 25'(BASE);
    localparam logic [24:0] HI = 25'(BASE + SPAN);

    logic        lo_ok;
    logic [24:0] rel;

    assign rel = {1'b0, addr} - LO;
    assign hit = lo_ok && (last < HI);

    generate
        if (BASE == 0) begin : g_zero_base
            assign lo_ok = 1'b1;
        end else begin : g_base
            assign lo_ok = ({1'b0, addr} >= LO);
        end

        if ((BASE % 2) == 1) begin : g_odd_lane
            assign off = OFF_W'(rel >> 1);
        end else begin : g_even
            assign off = OFF_W'(rel);
        end
    endgenerate

endmodule

// File: rtl/busdec_boot.sv
module busdec_boot
    import busdec_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        strobe,
    input  logic        rd,
    input  size_e       size,
    input  logic [23:0] addr,
    output logic        active
);
    typedef struct packed {
        logic boot;
    } boot_st_t;

    boot_st_t st_d, st_q;
    logic     last_vec;

    assign last_vec = strobe && rd && (size == SZ_LONG) && (addr == 24'd4);

    always_comb begin
        st_d = st_q;
        if (st_q.boot && last_vec) begin
            st_d.boot = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{boot: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign active = st_q.boot;

    p_boot_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (active && last_vec) |=> !active);

    p_boot_stays_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !active);

endmodule

// File: rtl/busdec_top.sv
module busdec_top
    import busdec_pkg::*;
#(
    parameter int unsigned RAM_SIZE     = 32'h100000,
    parameter int unsigned LOW_SIZE     = 32'h10000,
    parameter int unsigned ROM_BASE     = 32'h100000,
    parameter int unsigned ROM_SIZE     = 32'h10000,
    parameter int unsigned BIG_BASE     = 32'h180000,
    parameter int unsigned BIG_SPAN     = 32'h80000,
    parameter int unsigned N_BIG        = 2,
    parameter int unsigned SML_BASE     = 32'h3A0001,
    parameter int unsigned SML_SPAN     = 32'h4000,
    parameter int unsigned N_SML        = 8,
    parameter int unsigned OFF_W        = 20
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     strobe,
    input  logic                     rd,
    input  logic [1:0]               size,
    input  logic [23:0]              addr,
    output logic                     sel_ram,
    output logic                     sel_rom,
    output logic [N_BIG+N_SML-1:0]   sel_per,
    output logic [OFF_W-1:0]         mem_off,
    output logic [OFF_W-1:0]         per_off,
    output logic                     bus_err,
    output logic                     boot_active
);
    localparam int unsigned NPER = N_BIG + N_SML;

    typedef struct packed {
        logic             sel_ram;
        logic             sel_rom;
        logic [NPER-1:0]  sel_per;
        logic             err;
        logic [OFF_W-1:0] mem_off;
        logic [OFF_W-1:0] per_off;
    } dec_t;

    size_e       sz;
    logic [24:0] last;
    logic        ram_hit, low_hit, rom_hit;
    logic [OFF_W-1:0] ram_o, low_o, rom_o;
    logic [NPER-1:0]  per_hit;
    logic [OFF_W-1:0] per_o [NPER];
    dec_t        dec_d;

    assign sz   = size_e'(size);
    assign last = {1'b0, addr} + 25'(span_minus_one(sz));

    busdec_boot u_boot (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (strobe),
        .rd     (rd),
        .size   (sz),
        .addr   (addr),
        .active (boot_active)
    );

    busdec_win #(.BASE(LOW_SIZE), .SPAN(RAM_SIZE - LOW_SIZE), .OFF_W(OFF_W)) u_ram_sec (
        .addr(addr), .last(last), .hit(ram_hit), .off(ram_o));

    busdec_win #(.BASE(ROM_BASE), .SPAN(ROM_SIZE), .OFF_W(OFF_W)) u_rom (
        .addr(addr), .last(last), .hit(rom_hit), .off(rom_o));

    busdec_win #(.BASE(0), .SPAN(LOW_SIZE), .OFF_W(OFF_W)) u_ram_low (
        .addr(addr), .last(last), .hit(low_hit), .off(low_o));

    generate
        for (genvar k = 0; k < NPER; k++) begin : g_per
            localparam int unsigned PB = (k < N_BIG) ? (BIG_BASE + k * BIG_SPAN)
                                                     : (SML_BASE + (k - N_BIG) * SML_SPAN);
            localparam int unsigned PS = (k < N_BIG) ? BIG_SPAN : SML_SPAN;
            busdec_win #(.BASE(PB), .SPAN(PS), .OFF_W(OFF_W)) u_win (
                .addr(addr), .last(last), .hit(per_hit[k]), .off(per_o[k]));
        end
    endgenerate

    always_comb begin
        logic found;
        dec_d = '0;
        found = 1'b0;
        if (strobe) begin
            if (sz == SZ_BAD) begin
                dec_d.err = 1'b1;
            end else if (boot_active) begin
                if (rd && sz == SZ_LONG && (addr == 24'd0 || addr == 24'd4)) begin
                    dec_d.sel_rom = 1'b1;
                    dec_d.mem_off = OFF_W'(addr);
                end else begin
                    dec_d.err = 1'b1;
                end
            end else if (ram_hit) begin
                dec_d.sel_ram = 1'b1;
                dec_d.mem_off = ram_o + OFF_W'(LOW_SIZE);
            end else if (rom_hit && rd) begin
                dec_d.sel_rom = 1'b1;
                dec_d.mem_off = rom_o;
            end else begin
                for (int k = 0; k < NPER; k++) begin
                    if (!found && per_hit[k]) begin
                        found            = 1'b1;
                        dec_d.sel_per[k] = 1'b1;
                        dec_d.per_off    = per_o[k];
                    end
                end
                if (!found) begin
                    if (low_hit) begin
                        dec_d.sel_ram = 1'b1;
                        dec_d.mem_off = low_o;
                    end else begin
                        dec_d.err = 1'b1;
                    end
                end
            end
        end
    end

    assign sel_ram = dec_d.sel_ram;
    assign sel_rom = dec_d.sel_rom;
    assign sel_per = dec_d.sel_per;
    assign bus_err = dec_d.err;
    assign mem_off = dec_d.mem_off;
    assign per_off = dec_d.per_off;

    p_single_target_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_ram, sel_rom, sel_per, bus_err}));

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |-> !(sel_ram || sel_rom || (|sel_per) || bus_err));

    p_rom_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !rd) |-> !sel_rom);

    p_boot_vector_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_active && strobe && rd && size == 2'd2 && (addr == 24'd0 || addr == 24'd4))
        |-> (sel_rom && mem_off == OFF_W'(addr)));

    p_boot_refuse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_active && strobe && !(rd && size == 2'd2 && (addr == 24'd0 || addr == 24'd4)))
        |-> (bus_err && !sel_ram && (sel_per == '0)));

    p_bad_size_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && size == 2'd3) |-> bus_err);

endmodule

// File: tb/test_busdec_top.sv
module test_busdec_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strobe = 1'b0;
    logic        rd = 1'b1;
    logic [1:0]  size = 2'd0;
    logic [23:0] addr = '0;
    logic        sel_ram, sel_rom, bus_err, boot_active;
    logic [9:0]  sel_per;
    logic [19:0] mem_off, per_off;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    busdec_top i_busdec_top (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .rd(rd), .size(size), .addr(addr),
        .sel_ram(sel_ram), .sel_rom(sel_rom), .sel_per(sel_per), .mem_off(mem_off),
        .per_off(per_off), .bus_err(bus_err), .boot_active(boot_active)
    );

    typedef struct {
        logic        ram;
        logic        rom;
        logic [9:0]  per;
        logic        err;
        logic [19:0] moff;
        logic [19:0] poff;
        string       tag;
    } exp_t;

    function automatic exp_t model(logic [23:0] a, logic [1:0] sz, logic r, logic stb, logic boot);
        exp_t e;
        int   n, lst, ai, hit;
        e = '{ram: 0, rom: 0, per: '0, err: 0, moff: '0, poff: '0, tag: "R8"};
        ai = int'(a);
        if (!stb) begin e.tag = "R1"; return e; end
        if (sz == 2'd3) begin e.err = 1; e.tag = "R13"; return e; end
        n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        if (boot) begin
            if (r && sz == 2'd2 && (ai == 0 || ai == 4)) begin
                e.rom = 1; e.moff = 20'(ai); e.tag = "R9";
            end else begin
                e.err = 1; e.tag = "R10";
            end
            return e;
        end
        lst = ai + n - 1;
        if (ai >= 'h10000 && lst < 'h100000) begin
            e.ram = 1; e.moff = 20'(ai); e.tag = "R2"; return e;
        end
        if (r && ai >= 'h100000 && lst < 'h110000) begin
            e.rom = 1; e.moff = 20'(ai - 'h100000); e.tag = "R4"; return e;
        end
        hit = 0;
        for (int k = 0; k < 10; k++) begin
            int b, s;
            b = (k < 2) ? 'h180000 + k * 'h80000 : 'h3A0001 + (k - 2) * 'h4000;
            s = (k < 2) ? 'h80000 : 'h4000;
            if (hit == 0 && ai >= b && lst < b + s) begin
                hit = 1;
                e.per[k] = 1'b1;
                e.poff = (k < 2) ? 20'(ai - b) : 20'((ai - b) / 2);
                e.tag = (k < 2) ? "R6" : "R7";
            end
        end
        if (hit != 0) return e;
        if (lst < 'h10000) begin
            e.ram = 1; e.moff = 20'(ai); e.tag = "R2"; return e;
        end
        e.err = 1;
        if (!r && ai >= 'h100000 && ai < 'h110000) e.tag = "R5";
        else if (ai < 'h10000 && lst >= 'h10000) e.tag = "R3";
        else e.tag = "R8";
        return e;
    endfunction

    task automatic drive(logic [23:0] a, logic [1:0] sz, logic r, logic stb);
        @(negedge clk);
        addr = a; size = sz; rd = r; strobe = stb;
        #1;
    endtask

    task automatic compare(exp_t e);
        n_cmp++;
        if (sel_ram !== e.ram || sel_rom !== e.rom || sel_per !== e.per || bus_err !== e.err ||
            mem_off !== e.moff || per_off !== e.poff) begin
            n_bad++;
            $display("FAIL %s addr=%h size=%0d rd=%0b: got ram%0b rom%0b per%h err%0b moff%h poff%h, expected ram%0b rom%0b per%h err%0b moff%h poff%h",
                e.tag, addr, size, rd, sel_ram, sel_rom, sel_per, bus_err, mem_off, per_off,
                e.ram, e.rom, e.per, e.err, e.moff, e.poff);
        end
    endtask

    task automatic check_flag(logic got, logic want, string tag);
        n_cmp++;
        if (got !== want) begin
            n_bad++;
            $display("FAIL %s boot_active: got %0b expected %0b", tag, got, want);
        end
    endtask

    task automatic step(logic [23:0] a, logic [1:0] sz, logic r, logic stb, logic boot);
        drive(a, sz, r, stb);
        compare(model(a, sz, r, stb, boot));
    endtask

    initial begin : watchdog
        #(4 * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        int edges [12];
        edges = '{'h0, 'h10000, 'hFFFFC, 'h100000, 'h110000, 'h180000,
                  'h200000, 'h280000, 'h3A0001, 'h3A4001, 'h3BC001, 'h3C0001};
        repeat (3) @(posedge clk);
        #1;
        check_flag(boot_active, 1'b1, "R9");           // armed while in reset
        rst_n = 1'b1;
        // R1: idle after reset
        step(24'h0, 2'd2, 1'b1, 1'b0, 1'b1);
        check_flag(boot_active, 1'b1, "R11");
        // R9: first vector read, overlay stays
        step(24'h0, 2'd2, 1'b1, 1'b1, 1'b1);
        @(posedge clk); #1;
        check_flag(boot_active, 1'b1, "R11");
        // R10: other accesses refused during overlay
        step(24'h0, 2'd0, 1'b1, 1'b1, 1'b1);
        step(24'h4, 2'd2, 1'b0, 1'b1, 1'b1);
        step(24'h8, 2'd2, 1'b1, 1'b1, 1'b1);
        step(24'h4, 2'd1, 1'b1, 1'b1, 1'b1);
        step(24'h20000, 2'd0, 1'b1, 1'b1, 1'b1);
        step(24'h4, 2'd3, 1'b1, 1'b1, 1'b1);
        check_flag(boot_active, 1'b1, "R11");
        // R9 then R11: second vector read clears overlay
        step(24'h4, 2'd2, 1'b1, 1'b1, 1'b1);
        @(posedge clk); #1;
        check_flag(boot_active, 1'b0, "R11");
        step(24'h4, 2'd2, 1'b1, 1'b1, 1'b0);   // now plain RAM
        // sweep around every region edge
        foreach (edges[i]) begin
            for (int d = -4; d <= 4; d++) begin
                for (int s = 0; s < 4; s++) begin
                    for (int r = 0; r < 2; r++) begin
                        logic [23:0] a;
                        a = 24'(edges[i] + d);
                        step(a, 2'(s), 1'(r), 1'b1, 1'b0);
                    end
                end
                step(24'(edges[i] + d), 2'd2, 1'b1, 1'b0, 1'b0);   // R1
            end
        end
        // interior of each peripheral window, R6/R7
        for (int k = 0; k < 10; k++) begin
            int b;
            b = (k < 2) ? 'h180000 + k * 'h80000 : 'h3A0001 + (k - 2) * 'h4000;
            step(24'(b + 'h100), 2'd1, 1'b1, 1'b1, 1'b0);
            step(24'(b + 'h37), 2'd0, 1'b0, 1'b1, 1'b0);
        end
        // top of the map wraps, R8
        step(24'hFFFFFE, 2'd2, 1'b1, 1'b1, 1'b0);
        check_flag(boot_active, 1'b0, "R11");
        // R11: reset re-arms the overlay
        rst_n = 1'b0;
        #1;
        check_flag(boot_active, 1'b1, "R11");
        @(negedge clk);
        rst_n = 1'b1;
        step(24'h10, 2'd0, 1'b1, 1'b1, 1'b1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule